// File: doc/BRIEF.md
# Absolute Encoder Preset and Integrity Supervisor

This block supervises an absolute angle encoder. It receives a raw singleturn angle, an internally counted multiturn value and a multiturn value from an external turn sensor. It adds a programmable offset to the raw position to form the reported position. It also keeps sticky integrity flags: a turn-count disagreement, a bad configuration checksum and a bad offset-data checksum. These flags drive one active-low error indication, which serves both the position-read frame status bit and the error pin.

A zero-position preset can be started in three ways: a write of the value 2 to the command register, serial command 3, or a rising edge on a dedicated preset pin when that pin is enabled. During the preset, the block reports a zero position and pulls both the error and warning flags low. At the end of the preset it checks the stored preset data. If the data is good, it loads new offsets so that the current position reads as the stored preset value. If the data is bad, it asks for a chip reset instead.

Top module: `enc_supervisor`

## Requirements
- R1: After reset the offsets are zero, status is 000, err_n and warn_n are 1, preset_busy is 0 and reset_req is 0.
- R2: Outside a preset, pos_ang = (ang_raw + angle offset) mod 2^ANG_W and pos_mt = (mt_int + turn offset) mod 2^MT_W. Both are combinational from the inputs.
- R3: A cycle with mt_cmp_stb high and mt_int different from mt_ext sets status bit 0 at the next clock edge. With matching counts, the strobe leaves the bit unchanged.
- R4: A cycle with frame_done high sets status bit 1 if cfg_crc_ok is 0, and sets status bit 2 if ofs_crc_ok is 0, at the next edge. Without frame_done the checksum inputs have no effect.
- R5: err_n is 1 only when status is 000 and no preset is running. Otherwise it is 0.
- R6: A preset starts when any of these occurs: cmd_wr with cmd_wdata = 2, ser_cmd_vld with ser_cmd = 3, or a 0-to-1 change of preset_pin while preset_pin_en is 1. Other command values, and pin edges while the pin is disabled, start nothing.
- R7: preset_busy is high for exactly PRESET_CYCLES cycles after the triggering edge. While it is high, pos_ang and pos_mt read 0 and err_n and warn_n are 0. Outside a preset, warn_n is 1.
- R8: In the last busy cycle, if preset_crc_ok is 1, the offsets become (preset_ang - ang_raw) mod 2^ANG_W and (preset_mt - mt_int) mod 2^MT_W, using the input values of that cycle.
- R9: In the last busy cycle, if preset_crc_ok is 0, the offsets are kept and reset_req is high for exactly one cycle after that edge.
- R10: Preset triggers that arrive while preset_busy is high are ignored and do not lengthen the sequence.
- R11: clr_status clears all status bits at the next edge. A failure detected in the same cycle still sets its bit, because setting wins over clearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ang_raw | input | ANG_W | Raw singleturn angle |
| mt_int | input | MT_W | Internally counted turns |
| mt_ext | input | MT_W | Turns from the external sensor |
| mt_cmp_stb | input | 1 | Periodic turn comparison strobe |
| frame_done | input | 1 | A serial read cycle completed |
| cfg_crc_ok | input | 1 | Configuration checksum valid |
| ofs_crc_ok | input | 1 | Offset-data checksum valid |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command register write value |
| ser_cmd_vld | input | 1 | Serial command valid |
| ser_cmd | input | 4 | Serial command number |
| preset_pin | input | 1 | Dedicated preset input |
| preset_pin_en | input | 1 | Enable for the preset input |
| preset_ang | input | ANG_W | Stored preset angle |
| preset_mt | input | MT_W | Stored preset turn count |
| preset_crc_ok | input | 1 | Stored preset data checksum valid |
| clr_status | input | 1 | Clear sticky status bits |
| pos_ang | output | ANG_W | Reported angle |
| pos_mt | output | MT_W | Reported turn count |
| err_n | output | 1 | Active-low error flag for frames and pin |
| warn_n | output | 1 | Active-low warning flag for frames |
| status | output | 3 | Sticky flags: bit0 turns, bit1 config, bit2 offsets |
| preset_busy | output | 1 | Preset sequence running |
| reset_req | output | 1 | One-cycle chip reset request |

## Verification
Two pairs of events can meet in one cycle. The first pair is a status clear and a newly detected checksum or turn failure. The second pair is the last cycle of a preset and a fresh trigger. The bench forces both coincidences on purpose: it pulses clr_status together with a failing frame_done, and it issues a command on the exact edge that ends a preset. A behavioural model then decides the outcome each cycle: the new failure bit survives the clear, and the late trigger is dropped. Random traffic with sparse pulses adds further collisions, including frame checks that fall inside a running preset.

// File: rtl/enc_supervisor.sv
`timescale 1ns/1ps
module enc_supervisor #(
  parameter int ANG_W         = 14,
  parameter int MT_W          = 12,
  parameter int PRESET_CYCLES = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ANG_W-1:0] ang_raw,
  input  logic [MT_W-1:0]  mt_int,
  input  logic [MT_W-1:0]  mt_ext,
  input  logic             mt_cmp_stb,
  input  logic             frame_done,
  input  logic             cfg_crc_ok,
  input  logic             ofs_crc_ok,
  input  logic             cmd_wr,
  input  logic [7:0]       cmd_wdata,
  input  logic             ser_cmd_vld,
  input  logic [3:0]       ser_cmd,
  input  logic             preset_pin,
  input  logic             preset_pin_en,
  input  logic [ANG_W-1:0] preset_ang,
  input  logic [MT_W-1:0]  preset_mt,
  input  logic             preset_crc_ok,
  input  logic             clr_status,
  output logic [ANG_W-1:0] pos_ang,
  output logic [MT_W-1:0]  pos_mt,
  output logic             err_n,
  output logic             warn_n,
  output logic [2:0]       status,
  output logic             preset_busy,
  output logic             reset_req
);
  localparam int CNT_W = $clog2(PRESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PRESET_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             pin_q;
  logic [ANG_W-1:0] ofs_ang;
  logic [MT_W-1:0]  ofs_mt;
  logic [2:0]       fail;

  wire trig = !preset_busy &&
              ((cmd_wr && cmd_wdata == 8'd2) ||
               (ser_cmd_vld && ser_cmd == 4'd3) ||
               (preset_pin && !pin_q && preset_pin_en));
  wire last = preset_busy && cnt == '0;

  assign fail = {frame_done && !ofs_crc_ok,
                 frame_done && !cfg_crc_ok,
                 mt_cmp_stb && (mt_int != mt_ext)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_busy <= 1'b0;
      cnt         <= '0;
      pin_q       <= 1'b0;
      reset_req   <= 1'b0;
      ofs_ang     <= '0;
      ofs_mt      <= '0;
      status      <= '0;
    end else begin
      pin_q     <= preset_pin;
      reset_req <= last && !preset_crc_ok;
      status    <= (clr_status ? 3'b000 : status) | fail;
      if (trig) begin
        preset_busy <= 1'b1;
        cnt         <= CNT_LOAD;
      end else if (last) begin
        preset_busy <= 1'b0;
      end else if (preset_busy) begin
        cnt <= cnt - 1'b1;
      end
      if (last && preset_crc_ok) begin
        ofs_ang <= preset_ang - ang_raw;
        ofs_mt  <= preset_mt - mt_int;
      end
    end
  end

  assign pos_ang = preset_busy ? '0 : ang_raw + ofs_ang;
  assign pos_mt  = preset_busy ? '0 : mt_int + ofs_mt;
  assign err_n   = !preset_busy && status == 3'b000;
  assign warn_n  = !preset_busy;

  p_mt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mt_cmp_stb && mt_int != mt_ext) |=> (status[0] && !err_n));
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_status |=> ((status & $past(status)) == $past(status)));
  p_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    preset_busy |-> (pos_ang == '0 && pos_mt == '0 && !warn_n && !err_n));
  p_no_retrig_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_busy && cnt != '0) |=> preset_busy);
  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last && preset_crc_ok) |=> (ofs_ang == $past(ANG_W'(preset_ang - ang_raw))));
  p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  p_req_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (!preset_busy && $past(preset_busy)));
endmodule

// File: tb/test_enc_supervisor.sv
`timescale 1ns/1ps
module test_enc_supervisor;
  localparam int AW = 14, MW = 12, PC = 6;
  localparam int AM = 1 << AW, MM = 1 << MW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] ang_raw = 0, preset_ang = 0;
  logic [MW-1:0] mt_int = 0, mt_ext = 0, preset_mt = 0;
  logic mt_cmp_stb = 0, frame_done = 0, cfg_crc_ok = 1, ofs_crc_ok = 1;
  logic cmd_wr = 0, ser_cmd_vld = 0, preset_pin = 0, preset_pin_en = 0;
  logic preset_crc_ok = 1, clr_status = 0;
  logic [7:0] cmd_wdata = 0;
  logic [3:0] ser_cmd = 0;
  logic [AW-1:0] pos_ang;
  logic [MW-1:0] pos_mt;
  logic err_n, warn_n, preset_busy, reset_req;
  logic [2:0] status;

  int checks = 0, errors = 0;
  bit done = 0;

  enc_supervisor #(.ANG_W(AW), .MT_W(MW), .PRESET_CYCLES(PC)) i_enc_supervisor (
    .clk, .rst_n, .ang_raw, .mt_int, .mt_ext, .mt_cmp_stb, .frame_done,
    .cfg_crc_ok, .ofs_crc_ok, .cmd_wr, .cmd_wdata, .ser_cmd_vld, .ser_cmd,
    .preset_pin, .preset_pin_en, .preset_ang, .preset_mt, .preset_crc_ok,
    .clr_status, .pos_ang, .pos_mt, .err_n, .warn_n, .status, .preset_busy,
    .reset_req);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_busy = 0, m_left = 0, m_pin = 0, m_sts = 0, m_oa = 0, m_om = 0, m_rr = 0;

  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n) begin
        m_busy = 0; m_left = 0; m_pin = 0; m_sts = 0; m_oa = 0; m_om = 0; m_rr = 0;
      end else begin
        int f, go, fin;
        f = 0;
        if (mt_cmp_stb && mt_int != mt_ext) f += 1;
        if (frame_done && !cfg_crc_ok) f += 2;
        if (frame_done && !ofs_crc_ok) f += 4;
        go = (m_busy == 0) && ((cmd_wr && cmd_wdata == 2) || (ser_cmd_vld && ser_cmd == 3) ||
                               (preset_pin && m_pin == 0 && preset_pin_en));
        fin = (m_busy != 0) && m_left == 1;
        m_rr = (fin && !preset_crc_ok) ? 1 : 0;
        if (fin && preset_crc_ok) begin
          m_oa = (int'(preset_ang) - int'(ang_raw) + AM) % AM;
          m_om = (int'(preset_mt) - int'(mt_int) + MM) % MM;
        end
        m_sts = (clr_status ? 0 : m_sts) | f;
        m_pin = preset_pin;
        if (go) begin m_busy = 1; m_left = PC; end
        else if (fin) begin m_busy = 0; m_left = 0; end
        else if (m_busy != 0) m_left--;
      end
      #8;
      if (!done) begin
        chk(m_busy ? "R7 pos_ang" : "R2 R8 pos_ang", pos_ang,
            m_busy ? 0 : (int'(ang_raw) + m_oa) % AM);
        chk(m_busy ? "R7 pos_mt" : "R2 R8 pos_mt", pos_mt,
            m_busy ? 0 : (int'(mt_int) + m_om) % MM);
        chk("R3 R4 R11 status", status, m_sts);
        chk("R5 err_n", err_n, (m_busy == 0 && m_sts == 0) ? 1 : 0);
        chk("R7 warn_n", warn_n, m_busy ? 0 : 1);
        chk("R6 R10 preset_busy", preset_busy, m_busy);
        chk("R9 reset_req", reset_req, m_rr);
      end
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // R1 reset state
    chk("R1 status", status, 0); chk("R1 err_n", err_n, 1); chk("R1 warn_n", warn_n, 1);
    chk("R1 busy", preset_busy, 0); chk("R1 reset_req", reset_req, 0);
    ang_raw = 14'd1234; mt_int = 12'd77; mt_ext = 12'd77; #1;
    chk("R2 pos_ang zero offset", pos_ang, 1234);
    step(1);
    // R3 matching then mismatching turn counts
    mt_cmp_stb = 1; step(1); mt_cmp_stb = 0; step(1);
    chk("R3 match keeps status", status, 0);
    mt_ext = 12'd78; mt_cmp_stb = 1; step(1); mt_cmp_stb = 0; mt_ext = 12'd77; step(1);
    chk("R3 mismatch sets bit0", status, 1);
    clr_status = 1; step(1); clr_status = 0; step(1);
    // R4 checksum inputs ignored without frame_done
    cfg_crc_ok = 0; ofs_crc_ok = 0; step(2);
    chk("R4 no frame no effect", status, 0);
    frame_done = 1; ofs_crc_ok = 1; step(1); frame_done = 0; cfg_crc_ok = 1; step(1);
    chk("R4 config fail bit1", status, 2);
    // R11 clear together with a new failure
    clr_status = 1; frame_done = 1; ofs_crc_ok = 0; step(1);
    clr_status = 0; frame_done = 0; ofs_crc_ok = 1; step(1);
    chk("R11 set wins over clear", status, 4);
    clr_status = 1; step(1); clr_status = 0; step(1);
    // R6 ignored trigger forms
    cmd_wr = 1; cmd_wdata = 8'd5; ser_cmd_vld = 1; ser_cmd = 4'd7; preset_pin = 1;
    step(1); cmd_wr = 0; ser_cmd_vld = 0; preset_pin = 0; step(1);
    chk("R6 wrong codes ignored", preset_busy, 0);
    // R8 register-write preset with wraparound: preset 0, raw 1 -> offset max
    preset_ang = 0; preset_mt = 12'd5; ang_raw = 14'd1; mt_int = 12'd10;
    cmd_wr = 1; cmd_wdata = 8'd2; step(1); cmd_wr = 0;
    chk("R7 busy after write", preset_busy, 1);
    // R10 retrigger during busy ignored
    step(2); ser_cmd_vld = 1; ser_cmd = 4'd3; step(1); ser_cmd_vld = 0;
    step(PC - 3);
    chk("R10 sequence not lengthened", preset_busy, 0);
    chk("R8 wrapped angle reads preset", pos_ang, 0);
    chk("R8 turns read preset", pos_mt, 5);
    ang_raw = 14'd0; #1;
    chk("R8 wrap offset", pos_ang, AM - 1);
    // R6 serial command trigger, R9 checksum failure, trigger on last edge
    ser_cmd_vld = 1; ser_cmd = 4'd3; preset_crc_ok = 0; step(1); ser_cmd_vld = 0;
    step(PC - 1); cmd_wr = 1; cmd_wdata = 8'd2; step(1); cmd_wr = 0;
    chk("R9 reset_req pulse", reset_req, 1);
    chk("R10 trigger on last edge dropped", preset_busy, 0);
    chk("R9 offsets kept", pos_ang, AM - 1);
    step(1); chk("R9 pulse one cycle", reset_req, 0);
    preset_crc_ok = 1;
    // R6 pin disabled then enabled
    preset_pin = 1; step(1); preset_pin = 0; step(1);
    chk("R6 pin disabled", preset_busy, 0);
    preset_pin_en = 1; preset_pin = 1; step(1);
    chk("R6 pin edge", preset_busy, 1);
    step(PC + 2); preset_pin = 0; step(2);
    // random traffic checked by the model every cycle
    for (int i = 0; i < 3000; i++) begin
      ang_raw = AW'($urandom); mt_int = MW'($urandom);
      mt_ext = ($urandom % 4 == 0) ? MW'($urandom) : mt_int;
      mt_cmp_stb = ($urandom % 8 == 0); frame_done = ($urandom % 6 == 0);
      cfg_crc_ok = ($urandom % 5 != 0); ofs_crc_ok = ($urandom % 5 != 0);
      cmd_wr = ($urandom % 20 == 0); cmd_wdata = ($urandom % 2) ? 8'd2 : 8'($urandom);
      ser_cmd_vld = ($urandom % 25 == 0); ser_cmd = 4'($urandom);
      preset_pin = ($urandom % 10 == 0); preset_pin_en = ($urandom % 2 == 0);
      preset_ang = AW'($urandom); preset_mt = MW'($urandom);
      preset_crc_ok = ($urandom % 4 != 0); clr_status = ($urandom % 12 == 0);
      step(1);
    end
    step(2);
    summary();
  end
endmodule